// File: doc/BRIEF.md
# Byte Serial Transceiver Loopback and Timing Controller

This block is the digital core of a byte-wide serial transceiver. The transmit side takes 8-bit words and sends them out one bit at a time. The receive side collects serial bits and groups them back into 8-bit words. Between the two sides sit routing multiplexers for three loopback modes:

- Equipment loopback sends the transmit stream back into the receiver.
- Facility loopback sends the line input back out to the line output.
- Split loopback does both at once.

Every clock is modelled as a one-cycle enable on a single fast system clock. The analog synthesizer and the clock recovery circuit therefore stay outside the block, and only their enables and reference signals are seen here.

A timing selector picks where transmit timing comes from. There are three sources:

- The local synthesized clock.
- The line receive clock, used directly as a bypass.
- The local synthesized clock, but with the synthesizer reference taken from the receive clock divided by eight. This is the reference-loop mode.

The reference-loop mode is overridden while loss of signal is reported or equipment loopback is on. The block also runs a divider on the synthesized clock. Its ratio comes from a 3-bit code, and its output is the feedback pulse that is compared against the reference.

Every mode control passes through a synchronizer. The control is then applied only when the serializer sits between words.

Top module: `serdes_loop_ctrl`

## Requirements
- R1: The serializer sends the most significant bit first. It advances one bit per transmit tick, and `tx_ser_data` changes on the clock edge of that tick. On the tick that starts a word, it takes the word last captured on a `tx_par_stb` cycle.
- R2: The deserializer shifts in one bit per receive tick. The first bit received lands in bit 7. After every eighth bit, the new word appears on `rx_par_data` with `rx_par_stb` high for exactly one cycle.
- R3: With equipment loopback on, the deserializer is fed by the serializer output and clocked by the transmit tick. Because the serializer output is registered, each captured word is the sent word rotated right by one position.
- R4: With facility loopback on, `tx_ser_data` and `tx_ser_clk_en` follow the line input data and the selected receive tick combinationally. The receiver keeps deserializing the line input.
- R5: With both loopbacks on, `rx_par_data` and `rx_par_stb` follow `tx_par_data` and `tx_par_stb` combinationally, and R4 still holds.
- R6: With `lt_rx_bypass` in effect, the transmit tick is the selected receive tick and `synth_clk_en` has no effect on it. `tmode_eff` reads 01. This mode takes priority over the reference loop.
- R7: With the reference loop in effect, `cmu_ref_en` pulses once for every 8 selected receive ticks and ignores `ref_clk_en`. `tmode_eff` reads 10.
- R8: The reference loop is overridden while `los` or equipment loopback is in effect. In that case `tmode_eff` reads 00 and `cmu_ref_en` equals `ref_clk_en`.
- R9: With `cru_off` in effect, the raw receive clock enable replaces the recovered one everywhere the receive tick is used.
- R10: `div_sel` codes 0, 1, 2 and 3 give feedback ratios of 8, 12, 16 and 32. Codes 4 to 7 give 8. `div_ratio` reports the ratio, and `cmu_fb_en` pulses once per ratio synthesized ticks.
- R11: Each control input passes two synchronizer stages. It is then applied on an edge only when the serializer is between words (bit count 0). With the serializer idle, a control change shows on `tmode_eff` after the third clock edge.
- R12: After a synchronous reset, `tx_ser_data`, `rx_par_stb` and `rx_par_data` are 0 and `tmode_eff` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_par_data | input | 8 | Parallel transmit word |
| tx_par_stb | input | 1 | Low-speed transmit clock enable; captures the word |
| tx_ser_data | output | 1 | Serial transmit data |
| tx_ser_clk_en | output | 1 | Serial transmit clock enable |
| rx_ser_data | input | 1 | Serial line input |
| rx_rec_clk_en | input | 1 | Recovered receive clock enable |
| rx_raw_clk_en | input | 1 | Raw receive clock enable |
| rx_par_data | output | 8 | Parallel receive word |
| rx_par_stb | output | 1 | Receive word strobe / low-speed receive clock |
| synth_clk_en | input | 1 | Local synthesized serial clock enable |
| ref_clk_en | input | 1 | External reference clock enable |
| cmu_ref_en | output | 1 | Reference selected for the synthesizer |
| cmu_fb_en | output | 1 | Divided synthesized clock (feedback) |
| div_sel | input | 3 | Feedback ratio code |
| div_ratio | output | 6 | Decoded feedback ratio |
| lb_equip | input | 1 | Equipment loopback request |
| lb_facility | input | 1 | Facility loopback request |
| lt_rx_bypass | input | 1 | Transmit timing from receive clock |
| lt_ref_loop | input | 1 | Reference from divided receive clock |
| los | input | 1 | Loss of signal |
| cru_off | input | 1 | Use raw receive clock instead of recovered |
| tmode_eff | output | 2 | Timing mode in effect: 00 local, 01 bypass, 10 reference loop |

## Verification
Some properties are checked on every cycle:

- Timing mode changes happen only at a word boundary.
- The word strobe never lasts two cycles.
- The feedback pulse never repeats on consecutive cycles.
- A reference pulse in reference-loop mode always coincides with a receive tick.
- Loss of signal or equipment loopback always returns the reference to the external pin.

Bit order, the one-bit rotation under equipment loopback and the split-loopback routing can only be shown by the bench scenarios. The same holds for the choice of raw or recovered clock, the ratio table, the divide-by-eight reference rate and the three-edge control latency.

// File: rtl/slc_pkg.sv
`timescale 1ns/1ps
package slc_pkg;

    typedef enum logic [1:0] {
        TM_LOCAL   = 2'b00,
        TM_RXBYP   = 2'b01,
        TM_REFLOOP = 2'b10
    } tmode_e;

    typedef struct packed {
        logic equip;
        logic fac;
        logic rx_byp;
        logic ref_loop;
        logic los;
        logic cru_off;
    } ctrl_s;

    function automatic logic [5:0] ratio_of(input logic [2:0] sel);
        case (sel)
            3'd1:    ratio_of = 6'd12;
            3'd2:    ratio_of = 6'd16;
            3'd3:    ratio_of = 6'd32;
            default: ratio_of = 6'd8;
        endcase
    endfunction

    function automatic tmode_e resolve_mode(input ctrl_s c);
        if (c.rx_byp)
            resolve_mode = TM_RXBYP;
        else if (c.ref_loop && !c.los && !c.equip)
            resolve_mode = TM_REFLOOP;
        else
            resolve_mode = TM_LOCAL;
    endfunction

endpackage

// File: rtl/slc_ctrl_sync.sv
`timescale 1ns/1ps
module slc_ctrl_sync
    import slc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  ctrl_s  raw,
    input  logic   boundary,
    output ctrl_s  active,
    output tmode_e mode
);

    ctrl_s pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= raw;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[g] <= '0;
            else     pipe[g] <= pipe[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            mode   <= TM_LOCAL;
        end else if (boundary) begin
            active <= pipe[STAGES-1];
            mode   <= resolve_mode(pipe[STAGES-1]);
        end
    end

    // R11: controls only move when the serializer is between words
    assert_mode_at_boundary_R11: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> $past(boundary));

endmodule

// File: rtl/slc_ser.sv
`timescale 1ns/1ps
module slc_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load_stb,
    input  logic [W-1:0] load_data,
    output logic         ser_out,
    output logic         at_boundary
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  hold;
    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            sh      <= '0;
            cnt     <= '0;
            ser_out <= 1'b0;
        end else begin
            if (load_stb) hold <= load_data;
            if (tick) begin
                if (cnt == '0) begin
                    ser_out <= hold[W-1];
                    sh      <= {hold[W-2:0], 1'b0};
                end else begin
                    ser_out <= sh[W-1];
                    sh      <= {sh[W-2:0], 1'b0};
                end
                cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign at_boundary = (cnt == '0);

endmodule

// File: rtl/slc_deser.sv
`timescale 1ns/1ps
module slc_deser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         din,
    output logic [W-1:0] par_out,
    output logic         par_vld
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            par_out <= '0;
            par_vld <= 1'b0;
        end else begin
            par_vld <= 1'b0;
            if (tick) begin
                sh  <= {sh[W-2:0], din};
                cnt <= (cnt == CW'(W-1)) ? '0 : cnt + 1'b1;
                if (cnt == CW'(W-1)) begin
                    par_out <= {sh[W-2:0], din};
                    par_vld <= 1'b1;
                end
            end
        end
    end

    // R2: the word strobe is a single-cycle pulse
    assert_vld_single_R2: assert property (@(posedge clk) disable iff (rst)
        par_vld |=> !par_vld);

endmodule

// File: rtl/slc_clkdiv.sv
`timescale 1ns/1ps
module slc_clkdiv #(
    parameter int REF_DIV = 8,
    parameter int RW      = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          synth_tick,
    input  logic [RW-1:0] ratio,
    output logic          fb_pulse,
    input  logic          rx_tick,
    output logic          rx_div_pulse
);
    localparam int DW = $clog2(REF_DIV);

    logic [RW-1:0] fb_cnt;
    logic [DW-1:0] rx_cnt;
    logic          fb_wrap;

    assign fb_wrap      = (fb_cnt >= ratio - 1'b1);
    assign fb_pulse     = synth_tick && fb_wrap;
    assign rx_div_pulse = rx_tick && (rx_cnt == DW'(REF_DIV-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_cnt <= '0;
            rx_cnt <= '0;
        end else begin
            if (synth_tick) fb_cnt <= fb_wrap ? '0 : fb_cnt + 1'b1;
            if (rx_tick)    rx_cnt <= (rx_cnt == DW'(REF_DIV-1)) ? '0 : rx_cnt + 1'b1;
        end
    end

    // R10: the feedback pulse is never on two cycles in a row
    assert_fb_gap_R10: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

endmodule

// File: rtl/serdes_loop_ctrl.sv
`timescale 1ns/1ps
module serdes_loop_ctrl
    import slc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int REF_DIV     = 8,
    parameter int RATIO_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] tx_par_data,
    input  logic              tx_par_stb,
    output logic              tx_ser_data,
    output logic              tx_ser_clk_en,
    input  logic              rx_ser_data,
    input  logic              rx_rec_clk_en,
    input  logic              rx_raw_clk_en,
    output logic [BYTE_W-1:0] rx_par_data,
    output logic              rx_par_stb,
    input  logic              synth_clk_en,
    input  logic              ref_clk_en,
    output logic              cmu_ref_en,
    output logic              cmu_fb_en,
    input  logic [2:0]        div_sel,
    output logic [RATIO_W-1:0] div_ratio,
    input  logic              lb_equip,
    input  logic              lb_facility,
    input  logic              lt_rx_bypass,
    input  logic              lt_ref_loop,
    input  logic              los,
    input  logic              cru_off,
    output logic [1:0]        tmode_eff
);

    ctrl_s  raw_c;
    ctrl_s  act;
    tmode_e mode;
    logic   boundary;
    logic   line_rx_tick, tx_tick, deser_tick, deser_din;
    logic   ser_q, deser_vld, rx_div_pulse, split_on;
    logic   unused_ctrl;
    logic [BYTE_W-1:0] deser_q;

    assign raw_c = {lb_equip, lb_facility, lt_rx_bypass, lt_ref_loop, los, cru_off};

    slc_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_c), .boundary(boundary),
        .active(act), .mode(mode)
    );

    assign unused_ctrl  = act.ref_loop;
    assign line_rx_tick = act.cru_off ? rx_raw_clk_en : rx_rec_clk_en;
    assign tx_tick      = (act.fac || mode == TM_RXBYP) ? line_rx_tick : synth_clk_en;
    assign deser_tick   = act.equip ? tx_tick : line_rx_tick;
    assign deser_din    = act.equip ? ser_q : rx_ser_data;
    assign split_on     = act.equip && act.fac;

    slc_ser #(.W(BYTE_W)) u_ser (
        .clk(clk), .rst(rst), .tick(tx_tick), .load_stb(tx_par_stb),
        .load_data(tx_par_data), .ser_out(ser_q), .at_boundary(boundary)
    );

    slc_deser #(.W(BYTE_W)) u_deser (
        .clk(clk), .rst(rst), .tick(deser_tick), .din(deser_din),
        .par_out(deser_q), .par_vld(deser_vld)
    );

    slc_clkdiv #(.REF_DIV(REF_DIV), .RW(RATIO_W)) u_div (
        .clk(clk), .rst(rst), .synth_tick(synth_clk_en), .ratio(div_ratio),
        .fb_pulse(cmu_fb_en), .rx_tick(line_rx_tick), .rx_div_pulse(rx_div_pulse)
    );

    assign div_ratio     = RATIO_W'(ratio_of(div_sel));
    assign tx_ser_data   = act.fac ? rx_ser_data : ser_q;
    assign tx_ser_clk_en = tx_tick;
    assign rx_par_data   = split_on ? tx_par_data : deser_q;
    assign rx_par_stb    = split_on ? tx_par_stb : deser_vld;
    assign cmu_ref_en    = (mode == TM_REFLOOP) ? rx_div_pulse : ref_clk_en;
    assign tmode_eff     = mode;

    // R7: in reference-loop mode a reference pulse rides on a receive tick
    assert_ref_on_rx_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == TM_REFLOOP && cmu_ref_en) |-> line_rx_tick);

    // R8: loss of signal or equipment loopback hands the reference back to the pin
    assert_ref_forced_off_R8: assert property (@(posedge clk) disable iff (rst)
        (act.los || act.equip) |-> (cmu_ref_en == ref_clk_en));

endmodule

// File: tb/sim_serdes_loop_ctrl.sv
`timescale 1ns/1ps
module sim_serdes_loop_ctrl;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst;
    logic [7:0] tx_par_data, rx_par_data;
    logic       tx_par_stb, tx_ser_data, tx_ser_clk_en, rx_ser_data;
    logic       rx_rec_clk_en, rx_raw_clk_en, rx_par_stb;
    logic       synth_clk_en, ref_clk_en, cmu_ref_en, cmu_fb_en;
    logic [2:0] div_sel;
    logic [5:0] div_ratio;
    logic       lb_equip, lb_facility, lt_rx_bypass, lt_ref_loop, los, cru_off;
    logic [1:0] tmode_eff;

    serdes_loop_ctrl u0 (.*);

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tx_par_data = '0; tx_par_stb = 0; rx_ser_data = 0;
        rx_rec_clk_en = 0; rx_raw_clk_en = 0; synth_clk_en = 0; ref_clk_en = 0;
        div_sel = '0; lb_equip = 0; lb_facility = 0; lt_rx_bypass = 0;
        lt_ref_loop = 0; los = 0; cru_off = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load_word(input logic [7:0] w);
        tx_par_data = w; tx_par_stb = 1;
        @(negedge clk);
        tx_par_stb = 0;
    endtask

    // {equip, fac, byp, ref, los, mode[1:0], tx-from-rx, ref-from-rx}
    localparam logic [8:0] VEC [12] = '{
        9'b00000_00_0_0, 9'b00100_01_1_0, 9'b00010_10_0_1, 9'b00011_00_0_0,
        9'b10010_00_0_0, 9'b00110_01_1_0, 9'b01000_00_1_0, 9'b01010_10_1_1,
        9'b10000_00_0_0, 9'b11100_01_1_0, 9'b00001_00_0_0, 9'b00111_01_1_0
    };

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired R1..R12 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] got;
        int cnt;

        // R12 reset state
        do_reset();
        #1;
        chk("R12 tx_ser_data", tx_ser_data, 0);
        chk("R12 rx_par_stb", rx_par_stb, 0);
        chk("R12 rx_par_data", rx_par_data, 0);
        chk("R12 tmode_eff", tmode_eff, 0);

        // Mode table: R6 R7 R8 R4 routing of timing sources
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            {lb_equip, lb_facility, lt_rx_bypass, lt_ref_loop, los} = VEC[i][8:4];
            synth_clk_en = 1; ref_clk_en = 1; rx_rec_clk_en = 1; rx_raw_clk_en = 1;
            repeat (20) @(negedge clk);
            chk($sformatf("R6/R8 mode row %0d", i), tmode_eff, VEC[i][3:2]);
            rx_rec_clk_en = 0; rx_raw_clk_en = 0;
            #1;
            chk($sformatf("R6 tx tick synth row %0d", i), tx_ser_clk_en, !VEC[i][1]);
            chk($sformatf("R7/R8 ref pin row %0d", i), cmu_ref_en, !VEC[i][0]);
            @(negedge clk);
            synth_clk_en = 0; ref_clk_en = 0; rx_rec_clk_en = 1; rx_raw_clk_en = 1;
            #1;
            chk($sformatf("R6 tx tick rx row %0d", i), tx_ser_clk_en, VEC[i][1]);
        end

        // R1 serializer bit order
        do_reset();
        load_word(8'hA5);
        synth_clk_en = 1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            got[7-k] = tx_ser_data;
        end
        synth_clk_en = 0;
        chk("R1 serial MSB first", got, 8'hA5);

        // R3 equipment loopback, R2 strobe
        do_reset();
        lb_equip = 1;
        repeat (4) @(negedge clk);
        load_word(8'hA5);
        synth_clk_en = 1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 7) chk("R2 strobe after 8 ticks", rx_par_stb, 1);
            if (k == 8) chk("R2 strobe one cycle", rx_par_stb, 0);
            if (k == 15) begin
                chk("R3 equip strobe", rx_par_stb, 1);
                chk("R3 equip word rotated", rx_par_data, {1'b1, 7'b1010010});
            end
        end
        synth_clk_en = 0;

        // R4 facility loopback and R2 receive word
        do_reset();
        lb_facility = 1;
        repeat (4) @(negedge clk);
        got = 8'h96;
        for (int k = 0; k < 8; k++) begin
            rx_ser_data = got[7-k]; rx_rec_clk_en = 1;
            #1;
            chk("R4 line data looped out", tx_ser_data, got[7-k]);
            chk("R4 line clock looped out", tx_ser_clk_en, 1);
            @(negedge clk);
        end
        rx_rec_clk_en = 0;
        chk("R2 rx strobe", rx_par_stb, 1);
        chk("R2 rx word first bit in bit7", rx_par_data, 8'h96);
        @(negedge clk);
        chk("R2 rx strobe drops", rx_par_stb, 0);

        // R9 raw clock select
        do_reset();
        cru_off = 1;
        repeat (4) @(negedge clk);
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            rx_ser_data = 1; rx_rec_clk_en = 1;
            @(negedge clk);
            cnt += rx_par_stb;
        end
        rx_rec_clk_en = 0;
        chk("R9 recovered clock ignored", cnt, 0);
        got = 8'h3C;
        for (int k = 0; k < 8; k++) begin
            rx_ser_data = got[7-k]; rx_raw_clk_en = 1;
            @(negedge clk);
        end
        rx_raw_clk_en = 0;
        chk("R9 raw clock strobe", rx_par_stb, 1);
        chk("R9 raw clock word", rx_par_data, 8'h3C);

        // R5 split loopback
        do_reset();
        lb_equip = 1; lb_facility = 1;
        repeat (4) @(negedge clk);
        tx_par_data = 8'h5A; tx_par_stb = 1; rx_ser_data = 1; rx_rec_clk_en = 1;
        #1;
        chk("R5 split word", rx_par_data, 8'h5A);
        chk("R5 split strobe", rx_par_stb, 1);
        chk("R5 split serial data", tx_ser_data, 1);
        chk("R5 split serial clock", tx_ser_clk_en, 1);
        @(negedge clk);
        tx_par_stb = 0; rx_ser_data = 0; rx_rec_clk_en = 0;
        #1;
        chk("R5 split strobe low", rx_par_stb, 0);
        chk("R5 split serial data low", tx_ser_data, 0);

        // R7 reference from receive clock divided by eight
        do_reset();
        lt_ref_loop = 1;
        repeat (4) @(negedge clk);
        chk("R7 status", tmode_eff, 2);
        ref_clk_en = 1; rx_rec_clk_en = 1;
        cnt = 0;
        for (int k = 0; k < 64; k++) begin
            #1;
            cnt += cmu_ref_en;
            @(negedge clk);
        end
        rx_rec_clk_en = 0; ref_clk_en = 0;
        chk("R7 ref pulses per 64 rx ticks", cnt, 8);

        // R11 sync latency
        do_reset();
        lt_rx_bypass = 1;
        repeat (2) @(negedge clk);
        chk("R11 not yet after two edges", tmode_eff, 0);
        @(negedge clk);
        chk("R11 applied after third edge", tmode_eff, 1);

        // R11 wait for word boundary
        do_reset();
        synth_clk_en = 1;
        repeat (3) @(negedge clk);
        synth_clk_en = 0;
        lt_rx_bypass = 1;
        repeat (6) @(negedge clk);
        chk("R11 held mid word", tmode_eff, 0);
        synth_clk_en = 1;
        repeat (5) @(negedge clk);
        synth_clk_en = 0;
        chk("R11 still held before boundary edge", tmode_eff, 0);
        @(negedge clk);
        chk("R11 applied at boundary", tmode_eff, 1);

        // R10 feedback ratio
        do_reset();
        for (int s = 0; s < 8; s++) begin
            int exp_r;
            exp_r = (s == 1) ? 12 : (s == 2) ? 16 : (s == 3) ? 32 : 8;
            div_sel = 3'(s);
            synth_clk_en = 1;
            repeat (40) @(negedge clk);
            chk($sformatf("R10 ratio code %0d", s), div_ratio, exp_r);
            cnt = 0;
            for (int k = 0; k < 96; k++) begin
                #1;
                cnt += cmu_fb_en;
                @(negedge clk);
            end
            chk($sformatf("R10 fb pulses code %0d", s), cnt, 96 / exp_r);
        end
        synth_clk_en = 0;

        summary();
        $finish;
    end

endmodule